// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a three-level translation tree that sits in an ordinary word memory. A request carries the virtual address. The walker reads one entry per level through a single read port and tests each entry's present flag. It then answers with one of three outcomes: a physical address, a page fault that names the level where the walk stopped, or an address error. The address error is raised when the top-level index falls outside the table length that software has programmed.

Two plain control inputs set up the walk. The root pointer gives the byte address of the top-level table. The length limit gives how many top-level entries are legal. Requests come in on a valid/ready handshake, and the walker holds only one translation at a time. While a walk is running, or while its answer is waiting, `req_ready` stays low, so any request offered in that time is neither taken nor acted on. The answer is held on the response pins until the consumer raises `resp_ready`. This lets a slow consumer stall the walker for any number of cycles without losing the result.

Top module: `pt_walker`

## Requirements
- R1: While reset is held, and on the first cycle after it, `req_ready` is 1 and `resp_valid`, `mem_rd_en`, `resp_fault`, `resp_addr_err` and `resp_fault_level` are all 0.
- R2: The virtual address is split from the top down into four fields. Bits 31..24 are the top-level index, bits 23..18 the middle index, bits 17..12 the bottom index and bits 11..0 the page offset. The first read goes to `base_addr + 4*top_index`.
- R3: A table entry carries a 20-bit number in bits 31..12 and its present flag in bit 0. Bits 11..1 are ignored. After a present entry at level 1 or 2, the next read goes to `(number << 12) + 4*index_of_next_level`.
- R4: When all three entries are present, the walker makes exactly three reads. The response then has `resp_paddr = {level-3 number, page offset}`, with `resp_fault = 0` and `resp_addr_err = 0`.
- R5: If the entry read at level L (1, 2 or 3) has bit 0 clear, the walk stops after L reads. The response has `resp_fault = 1`, `resp_fault_level = L`, `resp_addr_err = 0` and `resp_paddr = 0`.
- R6: If the top-level index is greater than or equal to `l1_limit`, no table read is made. The response has `resp_addr_err = 1`, `resp_fault = 0`, `resp_fault_level = 0` and `resp_paddr = 0`.
- R7: Read data is taken on the clock edge one cycle after `mem_rd_en` is high. `mem_rd_en` is never high on two cycles in a row. The first cycle with `resp_valid` high comes 2*N cycles after the accepting edge, where N is the number of reads made.
- R8: `req_ready` is 1 only when the walker is idle. A request offered while a walk or its response is pending is ignored: it causes no read and does not change the response.
- R9: While `resp_valid` is 1 and `resp_ready` is 0, the response pins hold their values. The response is dropped on the edge where `resp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_addr | input | 32 | Byte address of the top-level table |
| l1_limit | input | 9 | Count of legal top-level entries (0..256) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and taking a request |
| req_vaddr | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | Translation result present |
| resp_ready | input | 1 | Consumer takes the result |
| resp_paddr | output | 32 | Physical address (0 on fault or error) |
| resp_fault | output | 1 | Walk stopped on an entry that is not present |
| resp_fault_level | output | 2 | Level (1..3) of that entry, 0 otherwise |
| resp_addr_err | output | 1 | Top-level index at or beyond `l1_limit` |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_data | input | 32 | Entry returned one cycle after the strobe |

## Verification
The bench builds the walker with its default parameters: a 32-bit address split 8/6/6/12, 32-bit entries and a 20-bit table or frame number. The table memory is modelled as a hash of the read address, so every one of the 2^20 table and frame numbers can appear without any storage in the bench. Absent entries show up both at random and on demand at each chosen level. The length limit is swept across 0, values in the middle, exactly the index under test, and 256. Together these reach every path: the full walk, a fault at each level, and the bounds error on both sides of the boundary.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_READ = 2'd1,
    WK_WAIT = 2'd2,
    WK_DONE = 2'd3
  } walk_state_t;

  localparam logic [1:0] LVL_TOP  = 2'd1;
  localparam logic [1:0] LVL_MID  = 2'd2;
  localparam logic [1:0] LVL_LEAF = 2'd3;

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split import pt_walker_pkg::*; #(
  parameter int VA_W  = 32,
  parameter int L1_W  = 8,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6,
  parameter int IDX_W = 8,
  parameter int OFF_W = VA_W - L1_W - L2_W - L3_W
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [1:0]       level,
  output logic [IDX_W-1:0] sel_idx,
  output logic [OFF_W-1:0] page_off
);

  localparam int TOP_HI  = VA_W - 1;
  localparam int MID_HI  = VA_W - L1_W - 1;
  localparam int LEAF_HI = VA_W - L1_W - L2_W - 1;

  logic [L1_W-1:0] idx_top;
  logic [L2_W-1:0] idx_mid;
  logic [L3_W-1:0] idx_leaf;

  assign idx_top  = vaddr[TOP_HI  -: L1_W];
  assign idx_mid  = vaddr[MID_HI  -: L2_W];
  assign idx_leaf = vaddr[LEAF_HI -: L3_W];
  assign page_off = vaddr[OFF_W-1:0];

  always_comb begin
    case (level)
      LVL_TOP:  sel_idx = IDX_W'(idx_top);
      LVL_MID:  sel_idx = IDX_W'(idx_mid);
      LVL_LEAF: sel_idx = IDX_W'(idx_leaf);
      default:  sel_idx = '0;
    endcase
  end

endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
  parameter int PTE_W = 32,
  parameter int NUM_W = 20,
  parameter int OFF_W = 12,
  parameter int PA_W  = NUM_W + OFF_W
) (
  input  logic [PTE_W-1:0] entry,
  output logic             ent_present,
  output logic [NUM_W-1:0] ent_num,
  output logic [PA_W-1:0]  ent_base
);

  localparam int RSVD_W = PTE_W - NUM_W - 1;

  assign ent_present = entry[0];
  assign ent_num     = entry[PTE_W-1 -: NUM_W];
  assign ent_base    = {ent_num, {OFF_W{1'b0}}};

  generate
    if (RSVD_W > 0) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ^entry[RSVD_W:1];
    end
  endgenerate

endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int PA_W        = 32,
  parameter int IDX_W       = 8,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  entry_addr
);

  logic [PA_W-1:0] idx_wide;

  assign idx_wide   = PA_W'(idx);
  assign entry_addr = tbl_base + (idx_wide << ENTRY_SHIFT);

endmodule

// File: rtl/pt_walker.sv
module pt_walker import pt_walker_pkg::*; #(
  parameter int VA_W        = 32,
  parameter int L1_W        = 8,
  parameter int L2_W        = 6,
  parameter int L3_W        = 6,
  parameter int NUM_W       = 20,
  parameter int PTE_W       = 32,
  parameter int ENTRY_SHIFT = 2,
  parameter int OFF_W       = VA_W - L1_W - L2_W - L3_W,
  parameter int PA_W        = NUM_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  base_addr,
  input  logic [L1_W:0]    l1_limit,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             resp_fault,
  output logic [1:0]       resp_fault_level,
  output logic             resp_addr_err,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic [PTE_W-1:0] mem_rd_data
);

  localparam int IDX_A = (L1_W > L2_W) ? L1_W : L2_W;
  localparam int IDX_W = (IDX_A > L3_W) ? IDX_A : L3_W;

  walk_state_t     state_q;
  logic [1:0]      level_q;
  logic [VA_W-1:0] vaddr_q;
  logic [PA_W-1:0] tbl_base_q;
  logic [PA_W-1:0] paddr_q;
  logic            fault_q;
  logic            err_q;
  logic [1:0]      flvl_q;

  logic [IDX_W-1:0] sel_idx;
  logic [OFF_W-1:0] page_off;
  logic             ent_present;
  logic [NUM_W-1:0] ent_num;
  logic [PA_W-1:0]  ent_base;
  logic [L1_W-1:0]  req_top_idx;
  logic             top_out_of_range;

  pt_va_split #(
    .VA_W (VA_W),
    .L1_W (L1_W),
    .L2_W (L2_W),
    .L3_W (L3_W),
    .IDX_W(IDX_W),
    .OFF_W(OFF_W)
  ) u_split (
    .vaddr   (vaddr_q),
    .level   (level_q),
    .sel_idx (sel_idx),
    .page_off(page_off)
  );

  pt_addr_gen #(
    .PA_W       (PA_W),
    .IDX_W      (IDX_W),
    .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_agen (
    .tbl_base  (tbl_base_q),
    .idx       (sel_idx),
    .entry_addr(mem_rd_addr)
  );

  pt_entry_decode #(
    .PTE_W(PTE_W),
    .NUM_W(NUM_W),
    .OFF_W(OFF_W),
    .PA_W (PA_W)
  ) u_dec (
    .entry      (mem_rd_data),
    .ent_present(ent_present),
    .ent_num    (ent_num),
    .ent_base   (ent_base)
  );

  assign req_top_idx      = req_vaddr[VA_W-1 -: L1_W];
  assign top_out_of_range = ({1'b0, req_top_idx} >= l1_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= WK_IDLE;
      level_q    <= 2'd0;
      vaddr_q    <= '0;
      tbl_base_q <= '0;
      paddr_q    <= '0;
      fault_q    <= 1'b0;
      err_q      <= 1'b0;
      flvl_q     <= 2'd0;
    end else begin
      case (state_q)
        WK_IDLE: begin
          if (req_valid) begin
            vaddr_q    <= req_vaddr;
            tbl_base_q <= base_addr;
            level_q    <= LVL_TOP;
            paddr_q    <= '0;
            fault_q    <= 1'b0;
            flvl_q     <= 2'd0;
            if (top_out_of_range) begin
              err_q   <= 1'b1;
              state_q <= WK_DONE;
            end else begin
              err_q   <= 1'b0;
              state_q <= WK_READ;
            end
          end
        end
        WK_READ: begin
          state_q <= WK_WAIT;
        end
        WK_WAIT: begin
          if (!ent_present) begin
            fault_q <= 1'b1;
            flvl_q  <= level_q;
            state_q <= WK_DONE;
          end else if (level_q == LVL_LEAF) begin
            paddr_q <= {ent_num, page_off};
            state_q <= WK_DONE;
          end else begin
            tbl_base_q <= ent_base;
            level_q    <= level_q + 2'd1;
            state_q    <= WK_READ;
          end
        end
        WK_DONE: begin
          if (resp_ready) state_q <= WK_IDLE;
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign req_ready        = (state_q == WK_IDLE);
  assign mem_rd_en        = (state_q == WK_READ);
  assign resp_valid       = (state_q == WK_DONE);
  assign resp_paddr       = paddr_q;
  assign resp_fault       = fault_q;
  assign resp_fault_level = flvl_q;
  assign resp_addr_err    = err_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            resp_valid,
  input logic            resp_ready,
  input logic [PA_W-1:0] resp_paddr,
  input logic            resp_fault,
  input logic [1:0]      resp_fault_level,
  input logic            resp_addr_err,
  input logic            mem_rd_en
);

  logic [2:0] rd_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_seen <= 3'd0;
    else if (req_valid && req_ready) rd_seen <= 3'd0;
    else if (mem_rd_en) rd_seen <= rd_seen + 3'd1;
  end

  AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready); // R8

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_en); // R8

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_paddr) &&
      $stable(resp_fault) && $stable(resp_fault_level) && $stable(resp_addr_err))); // R9

  AST_MAX_READS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (rd_seen < 3'd3)); // R4

  AST_FULL_WALK_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault && !resp_addr_err) |-> (rd_seen == 3'd3)); // R4

  AST_FAULT_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> ({1'b0, resp_fault_level} == rd_seen && resp_fault_level != 2'd0)); // R5

  AST_OUTCOME_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $countones({resp_fault, resp_addr_err}) <= 1); // R5

  AST_ERR_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_addr_err) |-> (rd_seen == 3'd0 && resp_paddr == '0)); // R6

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .resp_valid      (resp_valid),
  .resp_ready      (resp_ready),
  .resp_paddr      (resp_paddr),
  .resp_fault      (resp_fault),
  .resp_fault_level(resp_fault_level),
  .resp_addr_err   (resp_addr_err),
  .mem_rd_en       (mem_rd_en)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_addr = 32'h0004_0000;
  logic [8:0]  l1_limit = 9'd256;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b0;
  logic [31:0] resp_paddr;
  logic        resp_fault;
  logic [1:0]  resp_fault_level;
  logic        resp_addr_err;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;

  int checks = 0;
  int errors = 0;

  int          rd_cnt = 0;
  int          force_lvl = 0;
  logic [31:0] salt = 32'h1;
  logic [31:0] rd_log [3];
  logic [31:0] mem_e;

  logic [31:0] exp_paddr;
  logic        exp_fault;
  logic [1:0]  exp_lvl;
  logic        exp_err;
  int          exp_nrd;
  logic [31:0] exp_addr [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .base_addr       (base_addr),
    .l1_limit        (l1_limit),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_vaddr       (req_vaddr),
    .resp_valid      (resp_valid),
    .resp_ready      (resp_ready),
    .resp_paddr      (resp_paddr),
    .resp_fault      (resp_fault),
    .resp_fault_level(resp_fault_level),
    .resp_addr_err   (resp_addr_err),
    .mem_rd_en       (mem_rd_en),
    .mem_rd_addr     (mem_rd_addr),
    .mem_rd_data     (mem_rd_data)
  );

  function automatic logic [31:0] pte_at(input logic [31:0] addr, input logic [31:0] s);
    logic [31:0] h;
    h = (addr ^ s) * 32'h9E37_79B1;
    h = h ^ (h >> 13);
    h = h * 32'h85EB_CA6B;
    h = h ^ (h >> 16);
    return {h[31:1], (h[6:4] != 3'd0)};
  endfunction

  // table memory: one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_e = pte_at(mem_rd_addr, salt);
      if (rd_cnt + 1 == force_lvl) mem_e[0] = 1'b0;
      if (rd_cnt < 3) rd_log[rd_cnt] = mem_rd_addr;
      rd_cnt = rd_cnt + 1;
      mem_rd_data <= mem_e;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] va, input int frc);
    logic [31:0] tb;
    logic [31:0] e;
    logic [7:0]  idx [3];
    idx[0] = va[31:24];
    idx[1] = {2'b00, va[23:18]};
    idx[2] = {2'b00, va[17:12]};
    exp_paddr = '0; exp_fault = 1'b0; exp_lvl = 2'd0; exp_err = 1'b0; exp_nrd = 0;
    if ({1'b0, idx[0]} >= l1_limit) begin
      exp_err = 1'b1;
      return;
    end
    tb = base_addr;
    for (int l = 0; l < 3; l++) begin
      exp_addr[l] = tb + {22'd0, idx[l], 2'b00};
      e = pte_at(exp_addr[l], salt);
      if (l + 1 == frc) e[0] = 1'b0;
      exp_nrd = l + 1;
      if (!e[0]) begin
        exp_fault = 1'b1;
        exp_lvl = 2'(l + 1);
        return;
      end
      tb = {e[31:12], 12'd0};
      if (l == 2) exp_paddr = {e[31:12], va[11:0]};
    end
  endtask

  task automatic run_txn(input logic [31:0] va, input int frc, input int hold, input bit junk);
    int lat;
    string oreq;
    model(va, frc);
    oreq = exp_err ? "R6" : (exp_fault ? "R5" : "R4");
    @(negedge clk);
    force_lvl = frc;
    rd_cnt = 0;
    check(req_ready === 1'b1, "R8", "ready when idle", 32'(req_ready), 32'd1);
    req_vaddr = va;
    req_valid = 1'b1;
    @(posedge clk);
    #1;
    if (junk) req_vaddr = ~va;
    else req_valid = 1'b0;
    lat = 0;
    @(negedge clk);
    while (!resp_valid && lat < 40) begin
      if (junk) check(req_ready === 1'b0, "R8", "ready low while busy", 32'(req_ready), 32'd0);
      lat++;
      @(negedge clk);
    end
    check(lat == 2 * exp_nrd, "R7", "response latency", 32'(lat), 32'(2 * exp_nrd));
    check(rd_cnt == exp_nrd, oreq, "table read count", 32'(rd_cnt), 32'(exp_nrd));
    for (int i = 0; i < exp_nrd && i < rd_cnt; i++)
      check(rd_log[i] === exp_addr[i], (i == 0) ? "R2" : "R3", "entry read address",
            rd_log[i], exp_addr[i]);
    check(resp_addr_err === exp_err, "R6", "address error flag", 32'(resp_addr_err), 32'(exp_err));
    check(resp_fault === exp_fault, "R5", "page fault flag", 32'(resp_fault), 32'(exp_fault));
    check(resp_fault_level === exp_lvl, "R5", "fault level", 32'(resp_fault_level), 32'(exp_lvl));
    check(resp_paddr === exp_paddr, oreq, "physical address", resp_paddr, exp_paddr);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(resp_valid === 1'b1 && resp_paddr === exp_paddr && resp_fault === exp_fault &&
            resp_addr_err === exp_err && resp_fault_level === exp_lvl,
            "R9", "response held under back-pressure", resp_paddr, exp_paddr);
    end
    @(negedge clk);
    resp_ready = 1'b1;
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    resp_ready = 1'b0;
    @(negedge clk);
    check(resp_valid === 1'b0, "R9", "response dropped after accept", 32'(resp_valid), 32'd0);
    check(rd_cnt == exp_nrd, "R8", "no reads from ignored request", 32'(rd_cnt), 32'(exp_nrd));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && resp_valid === 1'b0 && mem_rd_en === 1'b0, "R1",
          "idle outputs in reset", {29'd0, req_ready, resp_valid, mem_rd_en}, 32'h4);
    check(resp_fault === 1'b0 && resp_addr_err === 1'b0 && resp_fault_level === 2'd0, "R1",
          "flags clear in reset", {28'd0, resp_fault, resp_addr_err, resp_fault_level}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && resp_valid === 1'b0 && mem_rd_en === 1'b0, "R1",
          "idle after reset", {29'd0, req_ready, resp_valid, mem_rd_en}, 32'h4);

    // directed: full walks and forced faults at each level
    run_txn(32'h1234_5678, 0, 0, 1'b0);            // R4
    run_txn(32'hA5C3_0FFF, 1, 0, 1'b0);            // R5 level 1
    run_txn(32'h0F0F_F000, 2, 0, 1'b0);            // R5 level 2
    run_txn(32'h7E81_2ABC, 3, 0, 1'b0);            // R5 level 3
    // bounds: limit edges
    l1_limit = 9'd16;
    run_txn(32'h0FFF_FFFF, 0, 0, 1'b0);            // index 15 legal, R2
    run_txn(32'h1000_0000, 0, 0, 1'b0);            // index 16 error, R6
    run_txn(32'hFF00_0000, 0, 0, 1'b0);            // index 255 error, R6
    l1_limit = 9'd0;
    run_txn(32'h0000_0000, 0, 0, 1'b0);            // nothing legal, R6
    l1_limit = 9'd256;
    run_txn(32'hFFFF_FFFF, 0, 0, 1'b0);            // top index 255 legal
    // back-pressure with junk requests while busy: R8, R9
    run_txn(32'h2468_ACE0, 0, 5, 1'b1);
    run_txn(32'h3000_0000, 2, 3, 1'b1);
    l1_limit = 9'd4;
    run_txn(32'h0800_0123, 0, 4, 1'b1);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] va;
      int frc;
      if (n % 50 == 0) salt = $urandom;
      if (n % 7 == 0) base_addr = {$urandom % 32'h000F_FFFF, 12'd0};
      l1_limit = ($urandom % 4 == 0) ? 9'($urandom % 257) : 9'd256;
      va = $urandom;
      frc = ($urandom % 6 == 0) ? int'(1 + $urandom % 3) : 0;
      run_txn(va, frc, int'($urandom % 4), 1'($urandom % 2));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule